// File: doc/BRIEF.md
# I2C Target Register Bridge

This block lets an I2C controller reach a bank of 32-bit registers inside the chip. It watches the two bus lines through synchronizers and picks out START, repeated START and STOP. It answers to one 7-bit target address. A mask can widen that address to a group of addresses, and the general call address is recognised on its own terms. Once the block is addressed for a write, the first byte it receives loads an 8-bit byte pointer. Each data byte after that fills one byte lane of a 32-bit word. The word is written to the register port once its most significant lane arrives.

For reads, the block fetches a whole register through a read strobe and then sends it out one byte at a time. While it waits for the register data it holds SCL low. A controller normally writes the pointer, issues a repeated START and then reads. The pointer keeps its value across START and STOP, so a later transfer can go on from where the last one stopped.

The two bus lines are open drain. The block never drives them high: each line has an output-enable that pulls it low.

Top module: `i2c_reg_bridge`

## Requirements
- R1: `busy_o` goes high after a START (SDA falls while SCL is high) and goes low after a STOP (SDA rises while SCL is high).
- R2: The first byte after a START is sent MSB first as the 7-bit address followed by a direction bit (0 = write, 1 = read). The block acknowledges a matching address by pulling SDA low during the ninth clock and raises `sel_o`. It does not acknowledge a non-matching address and ignores the bus until the next START.
- R3: An address matches when it equals `own_addr_i` in every bit position where `addr_mask_i` is 0. Bit positions where the mask is 1 are not compared.
- R4: Addresses whose upper four bits are 0000 or 1111 never give a normal match. Address 0000000 with the write bit is the general call: it is acknowledged, `gcall_o` is raised (with `sel_o` low), and the bytes that follow are acknowledged without any register access. Address 0000000 with the read bit is not acknowledged.
- R5: After a write address is acknowledged, the next byte loads the byte pointer. The register index is pointer bits [7:2], so registers lie four byte addresses apart.
- R6: Each written data byte goes into byte lane pointer[1:0] (lane 0 = bits 7:0), and the pointer then advances by one. `reg_we_o` pulses for one cycle after the lane-3 byte, with the complete word on `reg_wdata_o` and the index on `reg_addr_o`.
- R7: A read sends lane pointer[1:0] of register pointer[7:2], MSB first, and the pointer advances by one after each byte. `reg_re_o` pulses for the first byte of a read transfer and again whenever the lane reaches 0.
- R8: From each read strobe the block holds SCL low through `scl_oe_o`. It releases SCL only after `reg_rvalid_i` has delivered the data.
- R9: A repeated START is accepted without a STOP. The pointer keeps its value across START and STOP.
- R10: If the controller does not acknowledge a read byte, the block releases SDA and sends nothing more (no further read strobe) until the next START.
- R11: When `data_ack_en_i` is 0, bytes received after the address byte are not acknowledged and are discarded. No write strobe is issued and the pointer does not move.
- R12: Out of reset and after a STOP, `sda_oe_o`, `scl_oe_o`, `sel_o`, `gcall_o` and `busy_o` are all low.
- R13: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low (clock stretch) |
| sda_oe_o | output | 1 | Pull SDA low |
| own_addr_i | input | 7 | Target address |
| addr_mask_i | input | 7 | Address bits excluded from the match (1 = ignore) |
| data_ack_en_i | input | 1 | Acknowledge received bytes after the address |
| busy_o | output | 1 | Bus busy between START and STOP |
| sel_o | output | 1 | Addressed by own address in this transfer |
| gcall_o | output | 1 | Addressed by general call in this transfer |
| reg_addr_o | output | 6 | Register index |
| reg_wdata_o | output | 32 | Register write data |
| reg_we_o | output | 1 | Register write strobe |
| reg_re_o | output | 1 | Register read strobe |
| reg_rdata_i | input | 32 | Register read data |
| reg_rvalid_i | input | 1 | Read data valid |

## Verification
Address decoding is swept over all 128 addresses with no mask. This separates a true match from the general call and from misses. The sweep is then repeated over a 32-address window with two mask bits set, and with own addresses placed in the reserved groups, to show that masking widens the match while the reserved rule still wins. Writes are run from a word-aligned pointer and from a misaligned one, to separate lane placement from the strobe timing. Reads are run aligned and crossing a register boundary, with a slow register port, to show when the fetches and the clock stretching happen. Runs with a controller not-acknowledge and with acknowledge disabled show that the block goes quiet and that the pointer is kept.

// File: rtl/i2c_bridge_pkg.sv
package i2c_bridge_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_FETCH,
        ST_TX,
        ST_TX_ACK
    } bus_state_e;

    localparam logic [3:0] RSV_GROUP_LO = 4'b0000;
    localparam logic [3:0] RSV_GROUP_HI = 4'b1111;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s_o,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int LINES = 2;
    logic [LINES-1:0] raw;
    logic [LINES-1:0] cur;
    logic [LINES-1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] chain_d, chain_q;
        always_comb chain_d = {chain_q[STAGES-1:0], raw[g]};
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '1;
            else         chain_q <= chain_d;
        end
        assign cur[g]  = chain_q[STAGES-1];
        assign prev[g] = chain_q[STAGES];
    end

    assign scl_s_o    = cur[1];
    assign sda_s_o    = cur[0];
    assign scl_rise_o = cur[1] & ~prev[1];
    assign scl_fall_o = ~cur[1] & prev[1];
    assign start_o    = cur[1] & prev[1] & prev[0] & ~cur[0];
    assign stop_o     = cur[1] & prev[1] & ~prev[0] & cur[0];
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_bridge_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic [ADDR_W-1:0] mask_i,
    input  logic [ADDR_W:0]   byte_i,
    output logic              hit_o,
    output logic              gcall_o
);
    logic [ADDR_W-1:0] addr;
    logic              rw;
    logic [3:0]        group;
    logic              reserved;

    assign addr     = byte_i[ADDR_W:1];
    assign rw       = byte_i[0];
    assign group    = addr[ADDR_W-1 -: 4];
    assign reserved = (group == RSV_GROUP_LO) || (group == RSV_GROUP_HI);
    assign hit_o    = !reserved && (((addr ^ own_addr_i) & ~mask_i) == '0);
    assign gcall_o  = (addr == '0) && !rw;
endmodule

// File: rtl/i2c_tgt_core.sv
module i2c_tgt_core
    import i2c_bridge_pkg::*;
#(
    parameter int PTR_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      sda_s_i,
    input  logic                      scl_rise_i,
    input  logic                      scl_fall_i,
    input  logic                      start_i,
    input  logic                      stop_i,
    input  logic                      hit_i,
    input  logic                      gcall_i,
    input  logic                      data_ack_en_i,
    input  logic [DATA_W-1:0]         reg_rdata_i,
    input  logic                      reg_rvalid_i,
    output logic [7:0]                byte_o,
    output logic                      sda_oe_o,
    output logic                      scl_oe_o,
    output logic                      busy_o,
    output logic                      sel_o,
    output logic                      gcall_o,
    output logic [PTR_W-3:0]          reg_addr_o,
    output logic [DATA_W-1:0]         reg_wdata_o,
    output logic                      reg_we_o,
    output logic                      reg_re_o
);
    localparam int BYTES  = DATA_W / 8;
    localparam int LANE_W = $clog2(BYTES);
    localparam int WORD_W = PTR_W - LANE_W;
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(BYTES - 1);

    typedef struct packed {
        bus_state_e        state;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic [PTR_W-1:0]  ptr;
        logic [WORD_W-1:0] word;
        logic [DATA_W-1:0] wbuf;
        logic [DATA_W-1:0] rbuf;
        logic              rd;
        logic              gc;
        logic              sel;
        logic              need_ptr;
        logic              first;
        logic              mack;
        logic              sda_oe;
        logic              scl_oe;
        logic              we;
        logic              re;
        logic              busy;
    } core_t;

    core_t d, q;

    // Prepare the next byte to send: fetch a fresh word or take a lane.
    function automatic core_t begin_tx(core_t s);
        core_t            r;
        logic [LANE_W-1:0] lane;
        r    = s;
        lane = s.ptr[LANE_W-1:0];
        if (lane == '0 || s.first) begin
            r.re     = 1'b1;
            r.word   = s.ptr[PTR_W-1:LANE_W];
            r.scl_oe = 1'b1;
            r.first  = 1'b0;
            r.state  = ST_FETCH;
        end else begin
            r.sh     = s.rbuf[8*lane +: 8];
            r.sda_oe = ~s.rbuf[8*lane + 7];
            r.cnt    = '0;
            r.state  = ST_TX;
        end
        return r;
    endfunction

    logic [LANE_W-1:0] lane_q;
    assign lane_q = q.ptr[LANE_W-1:0];

    always_comb begin
        d    = q;
        d.we = 1'b0;
        d.re = 1'b0;
        unique case (q.state)
            ST_IDLE: ;
            ST_ADDR: begin
                if (scl_rise_i) begin
                    d.sh  = {q.sh[6:0], sda_s_i};
                    d.cnt = q.cnt + 4'd1;
                end else if (scl_fall_i && q.cnt == 4'd8) begin
                    d.cnt = '0;
                    if (gcall_i) begin
                        d.gc     = 1'b1;
                        d.rd     = 1'b0;
                        d.sda_oe = 1'b1;
                        d.state  = ST_ADDR_ACK;
                    end else if (hit_i) begin
                        d.sel    = 1'b1;
                        d.rd     = q.sh[0];
                        d.sda_oe = 1'b1;
                        d.state  = ST_ADDR_ACK;
                    end else begin
                        d.state  = ST_IDLE;
                    end
                end
            end
            ST_ADDR_ACK: begin
                if (scl_fall_i) begin
                    d.sda_oe = 1'b0;
                    if (q.rd) begin
                        d = begin_tx(d);
                    end else begin
                        d.need_ptr = !q.gc;
                        d.state    = ST_RX;
                    end
                end
            end
            ST_RX: begin
                if (scl_rise_i) begin
                    d.sh  = {q.sh[6:0], sda_s_i};
                    d.cnt = q.cnt + 4'd1;
                end else if (scl_fall_i && q.cnt == 4'd8) begin
                    d.cnt = '0;
                    if (!data_ack_en_i) begin
                        d.state = ST_IDLE;
                    end else begin
                        d.sda_oe = 1'b1;
                        d.state  = ST_RX_ACK;
                        if (q.need_ptr) begin
                            d.ptr      = PTR_W'(q.sh);
                            d.need_ptr = 1'b0;
                        end else if (!q.gc) begin
                            d.wbuf[8*lane_q +: 8] = q.sh;
                            d.ptr = q.ptr + PTR_W'(1);
                            if (lane_q == LAST_LANE) begin
                                d.we   = 1'b1;
                                d.word = q.ptr[PTR_W-1:LANE_W];
                            end
                        end
                    end
                end
            end
            ST_RX_ACK: begin
                if (scl_fall_i) begin
                    d.sda_oe = 1'b0;
                    d.state  = ST_RX;
                end
            end
            ST_FETCH: begin
                if (reg_rvalid_i) begin
                    d.rbuf   = reg_rdata_i;
                    d.sh     = reg_rdata_i[8*lane_q +: 8];
                    d.sda_oe = ~reg_rdata_i[8*lane_q + 7];
                    d.cnt    = '0;
                    d.state  = ST_TX;
                end
            end
            ST_TX: begin
                d.scl_oe = 1'b0;
                if (scl_fall_i) begin
                    if (q.cnt == 4'd7) begin
                        d.sda_oe = 1'b0;
                        d.ptr    = q.ptr + PTR_W'(1);
                        d.state  = ST_TX_ACK;
                    end else begin
                        d.cnt    = q.cnt + 4'd1;
                        d.sh     = {q.sh[6:0], 1'b0};
                        d.sda_oe = ~q.sh[6];
                    end
                end
            end
            ST_TX_ACK: begin
                if (scl_rise_i) begin
                    d.mack = !sda_s_i;
                end else if (scl_fall_i) begin
                    if (q.mack) d = begin_tx(d);
                    else        d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase

        if (start_i) begin
            d.state    = ST_ADDR;
            d.cnt      = '0;
            d.busy     = 1'b1;
            d.sel      = 1'b0;
            d.gc       = 1'b0;
            d.sda_oe   = 1'b0;
            d.scl_oe   = 1'b0;
            d.first    = 1'b1;
            d.need_ptr = 1'b0;
        end
        if (stop_i) begin
            d.state  = ST_IDLE;
            d.busy   = 1'b0;
            d.sel    = 1'b0;
            d.gc     = 1'b0;
            d.sda_oe = 1'b0;
            d.scl_oe = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign byte_o      = q.sh;
    assign sda_oe_o    = q.sda_oe;
    assign scl_oe_o    = q.scl_oe;
    assign busy_o      = q.busy;
    assign sel_o       = q.sel;
    assign gcall_o     = q.gc;
    assign reg_addr_o  = q.word;
    assign reg_wdata_o = q.wbuf;
    assign reg_we_o    = q.we;
    assign reg_re_o    = q.re;
endmodule

// File: rtl/i2c_reg_bridge.sv
module i2c_reg_bridge #(
    parameter int ADDR_W = 7,
    parameter int PTR_W  = 8,
    parameter int DATA_W = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe_o,
    output logic              sda_oe_o,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic [ADDR_W-1:0] addr_mask_i,
    input  logic              data_ack_en_i,
    output logic              busy_o,
    output logic              sel_o,
    output logic              gcall_o,
    output logic [PTR_W-3:0]  reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              reg_we_o,
    output logic              reg_re_o,
    input  logic [DATA_W-1:0] reg_rdata_i,
    input  logic              reg_rvalid_i
);
    logic       scl_s_w, sda_s_w, scl_rise_w, scl_fall_w, start_w, stop_w;
    logic       hit_w, gc_w;
    logic [7:0] byte_w;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_s_o    (scl_s_w),
        .sda_s_o    (sda_s_w),
        .scl_rise_o (scl_rise_w),
        .scl_fall_o (scl_fall_w),
        .start_o    (start_w),
        .stop_o     (stop_w)
    );

    i2c_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .own_addr_i (own_addr_i),
        .mask_i     (addr_mask_i),
        .byte_i     (byte_w[ADDR_W:0]),
        .hit_o      (hit_w),
        .gcall_o    (gc_w)
    );

    i2c_tgt_core #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_core (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .sda_s_i       (sda_s_w),
        .scl_rise_i    (scl_rise_w),
        .scl_fall_i    (scl_fall_w),
        .start_i       (start_w),
        .stop_i        (stop_w),
        .hit_i         (hit_w),
        .gcall_i       (gc_w),
        .data_ack_en_i (data_ack_en_i),
        .reg_rdata_i   (reg_rdata_i),
        .reg_rvalid_i  (reg_rvalid_i),
        .byte_o        (byte_w),
        .sda_oe_o      (sda_oe_o),
        .scl_oe_o      (scl_oe_o),
        .busy_o        (busy_o),
        .sel_o         (sel_o),
        .gcall_o       (gcall_o),
        .reg_addr_o    (reg_addr_o),
        .reg_wdata_o   (reg_wdata_o),
        .reg_we_o      (reg_we_o),
        .reg_re_o      (reg_re_o)
    );
endmodule

// File: rtl/i2c_reg_bridge_chk.sv
module i2c_reg_bridge_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic start_i,
    input logic stop_i,
    input logic scl_s_i,
    input logic busy_i,
    input logic sel_i,
    input logic sda_oe_i,
    input logic scl_oe_i,
    input logic reg_we_i,
    input logic reg_re_i,
    input logic reg_rvalid_i
);
    logic got_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           got_q <= 1'b0;
        else if (reg_re_i)     got_q <= 1'b0;
        else if (reg_rvalid_i) got_q <= 1'b1;
    end

    assert_start_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> busy_i);

    assert_stop_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> (!busy_i && !sel_i && !sda_oe_i && !scl_oe_i));

    assert_release_after_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(scl_oe_i) |-> got_q);

    assert_stretch_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scl_oe_i |-> !scl_s_i);

    assert_we_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_we_i |=> !reg_we_i);

    assert_sda_quiet_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scl_s_i && $past(scl_s_i)) |-> $stable(sda_oe_i));
endmodule

bind i2c_reg_bridge i2c_reg_bridge_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_w),
    .stop_i       (stop_w),
    .scl_s_i      (scl_s_w),
    .busy_i       (busy_o),
    .sel_i        (sel_o),
    .sda_oe_i     (sda_oe_o),
    .scl_oe_i     (scl_oe_o),
    .reg_we_i     (reg_we_o),
    .reg_re_i     (reg_re_o),
    .reg_rvalid_i (reg_rvalid_i)
);

// File: tb/i2c_reg_bridge_tb_top.sv
`timescale 1ns/1ps
module i2c_reg_bridge_tb_top;
    localparam int Q   = 8;
    localparam int LAT = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_oe, sda_oe, scl_line, sda_line;
    logic [6:0] own = 7'h2A, mask = 7'h00;
    logic ack_en = 1'b1;
    logic busy, sel, gcall, we, re, rvalid = 1'b0;
    logic [5:0]  raddr;
    logic [31:0] wdata, rdata = '0;

    assign scl_line = scl_m & ~scl_oe;
    assign sda_line = sda_m & ~sda_oe;

    i2c_reg_bridge dut_i (
        .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .own_addr_i(own),
        .addr_mask_i(mask), .data_ack_en_i(ack_en), .busy_o(busy),
        .sel_o(sel), .gcall_o(gcall), .reg_addr_o(raddr),
        .reg_wdata_o(wdata), .reg_we_o(we), .reg_re_o(re),
        .reg_rdata_i(rdata), .reg_rvalid_i(rvalid)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    function automatic logic [31:0] exp_word(input int i);
        logic [7:0] b;
        b = i[7:0];
        return {b ^ 8'hA5, b + 8'h10, ~b, b * 8'd3};
    endfunction

    function automatic bit exp_ack(input logic [6:0] a, input logic rw);
        bit rsv;
        rsv = (a[6:3] == 4'h0) || (a[6:3] == 4'hF);
        return (a == 7'h00 && !rw) || (!rsv && (((a ^ own) & ~mask) == 7'h00));
    endfunction

    // register bank and port monitor
    logic [31:0] bank [64];
    int re_cnt = 0, we_cnt = 0, lat_cnt = 0;
    logic [5:0]  paddr = '0;
    logic [5:0]  cap_addr [4];
    logic [31:0] cap_data [4];
    bit stretch_seen = 1'b0;

    initial for (int i = 0; i < 64; i++) bank[i] = exp_word(i);

    always @(negedge clk) begin
        rvalid = 1'b0;
        if (lat_cnt > 0) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
                rvalid = 1'b1;
                rdata  = bank[paddr];
            end
        end
        if (re) begin
            re_cnt++;
            paddr   = raddr;
            lat_cnt = LAT;
        end
        if (we) begin
            cap_addr[we_cnt % 4] = raddr;
            cap_data[we_cnt % 4] = wdata;
            bank[raddr] = wdata;
            we_cnt++;
        end
        if (scl_oe && scl_m) stretch_seen = 1'b1;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic t_start();
        sda_m = 1'b1; scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic t_rstart();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; wait_scl_high(); tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic t_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; wait_scl_high(); tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic bit_w(input logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; wait_scl_high(); tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bit_r(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; wait_scl_high(); tick(Q);
        b = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic wr_byte(input logic [7:0] v, output bit acked);
        logic x;
        for (int i = 7; i >= 0; i--) bit_w(v[i]);
        bit_r(x);
        acked = !x;
    endtask

    task automatic rd_byte(input bit give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) bit_r(v[i]);
        bit_w(!give_ack);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog: actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit ak;
        logic [7:0] b;
        tick(4);
        check(!busy && !sda_oe && !scl_oe && !sel && !gcall, "R12", "reset idle",
              {busy, sda_oe, scl_oe, sel, gcall}, 0);
        rst_n = 1'b1;
        tick(4);

        // R2/R4: full address sweep, no mask
        for (int a = 0; a < 128; a++) begin
            t_start();
            check(busy == 1'b1, "R1", "busy after START", busy, 1);
            wr_byte({a[6:0], 1'b0}, ak);
            check(ak == exp_ack(a[6:0], 1'b0), "R2", $sformatf("ack addr %0h", a), ak, exp_ack(a[6:0], 1'b0));
            check(gcall == (a == 0), "R4", "gcall flag", gcall, a == 0);
            check(sel == (exp_ack(a[6:0], 1'b0) && a != 0), "R2", "sel flag", sel, a != 0 && exp_ack(a[6:0], 1'b0));
            t_stop();
            check(!busy && !sel && !gcall && !sda_oe, "R12", "idle after STOP", {busy, sel, gcall, sda_oe}, 0);
        end

        // R3: masked match over a window
        mask = 7'h03;
        for (int a = 32; a < 64; a++) begin
            t_start();
            wr_byte({a[6:0], 1'b0}, ak);
            check(ak == exp_ack(a[6:0], 1'b0), "R3", $sformatf("masked ack addr %0h", a), ak, exp_ack(a[6:0], 1'b0));
            t_stop();
        end
        mask = 7'h00;

        // R4: reserved groups never match; general call read is refused
        foreach (b[i]) ;
        for (int k = 0; k < 2; k++) begin
            own = (k == 0) ? 7'h05 : 7'h78;
            t_start();
            wr_byte({own, 1'b0}, ak);
            check(!ak, "R4", "reserved own address", ak, 0);
            t_stop();
        end
        own = 7'h2A;
        t_start();
        wr_byte(8'h01, ak);
        check(!ak, "R4", "general call with read bit", ak, 0);
        t_stop();

        // R6: aligned write of two registers
        we_cnt = 0;
        t_start();
        wr_byte({own, 1'b0}, ak);
        wr_byte(8'h08, ak);
        check(ak, "R5", "pointer byte ack", ak, 1);
        for (int i = 1; i <= 8; i++) begin
            wr_byte(8'(i * 8'h11), ak);
            if (i == 3) check(we_cnt == 0, "R6", "no strobe before lane 3", we_cnt, 0);
        end
        t_stop();
        check(we_cnt == 2, "R6", "write strobe count", we_cnt, 2);
        check(cap_addr[0] == 6'd2, "R5", "first word index", cap_addr[0], 2);
        check(cap_data[0] == 32'h44332211, "R6", "first word data", cap_data[0], 32'h44332211);
        check(cap_addr[1] == 6'd3, "R6", "second word index", cap_addr[1], 3);
        check(cap_data[1] == 32'h88776655, "R6", "second word data", cap_data[1], 32'h88776655);

        // R6: misaligned write, lanes 1..3 of register 4
        we_cnt = 0;
        t_start();
        wr_byte({own, 1'b0}, ak);
        wr_byte(8'h11, ak);
        wr_byte(8'hAA, ak); wr_byte(8'hBB, ak); wr_byte(8'hCC, ak);
        t_stop();
        check(we_cnt == 1 && cap_addr[0] == 6'd4, "R6", "misaligned strobe", cap_addr[0], 4);
        check(cap_data[0][31:8] == 24'hCCBBAA, "R6", "misaligned lanes", cap_data[0][31:8], 24'hCCBBAA);

        // R7/R8/R9: pointer write, repeated START, read across a boundary
        re_cnt = 0; stretch_seen = 1'b0;
        t_start();
        wr_byte({own, 1'b0}, ak);
        wr_byte(8'h28, ak);
        t_rstart();
        wr_byte({own, 1'b1}, ak);
        check(ak, "R9", "read address after repeated START", ak, 1);
        for (int i = 0; i < 6; i++) begin
            logic [31:0] w;
            w = exp_word(10 + i / 4);
            rd_byte(i != 5, b);
            check(b == w[8 * (i % 4) +: 8], "R7", $sformatf("read byte %0d", i), b, w[8 * (i % 4) +: 8]);
        end
        t_stop();
        check(re_cnt == 2, "R7", "read strobes", re_cnt, 2);
        check(stretch_seen, "R8", "clock stretched during fetch", stretch_seen, 1);

        // R7: misaligned read from pointer 0x1A
        re_cnt = 0;
        t_start();
        wr_byte({own, 1'b0}, ak);
        wr_byte(8'h1A, ak);
        t_rstart();
        wr_byte({own, 1'b1}, ak);
        rd_byte(1'b1, b); check(b == exp_word(6)[23:16], "R7", "lane 2", b, exp_word(6)[23:16]);
        rd_byte(1'b1, b); check(b == exp_word(6)[31:24], "R7", "lane 3", b, exp_word(6)[31:24]);
        rd_byte(1'b0, b); check(b == exp_word(7)[7:0], "R7", "next register lane 0", b, exp_word(7)[7:0]);
        t_stop();
        check(re_cnt == 2, "R7", "misaligned read strobes", re_cnt, 2);

        // R10: controller NACK stops the read
        re_cnt = 0;
        t_start();
        wr_byte({own, 1'b0}, ak);
        wr_byte(8'h28, ak);
        t_rstart();
        wr_byte({own, 1'b1}, ak);
        rd_byte(1'b0, b);
        check(b == exp_word(10)[7:0], "R10", "byte before NACK", b, exp_word(10)[7:0]);
        rd_byte(1'b0, b);
        check(b == 8'hFF, "R10", "released after NACK", b, 8'hFF);
        check(re_cnt == 1, "R10", "no fetch after NACK", re_cnt, 1);
        t_stop();

        // R11: acknowledge disabled discards data and keeps the pointer
        we_cnt = 0;
        t_start();
        wr_byte({own, 1'b0}, ak);
        wr_byte(8'h20, ak);
        ack_en = 1'b0;
        wr_byte(8'h55, ak);
        check(!ak, "R11", "data byte not acknowledged", ak, 0);
        for (int i = 0; i < 3; i++) wr_byte(8'h66, ak);
        t_stop();
        check(we_cnt == 0, "R11", "no write strobe", we_cnt, 0);
        ack_en = 1'b1;
        t_start();
        wr_byte({own, 1'b1}, ak);
        rd_byte(1'b0, b);
        check(b == exp_word(8)[7:0], "R11", "pointer unchanged (R9 kept across STOP)", b, exp_word(8)[7:0]);
        t_stop();

        // R4: general call bytes acknowledged without register access
        we_cnt = 0;
        t_start();
        wr_byte(8'h00, ak);
        check(ak && gcall && !sel, "R4", "general call accepted", {ak, gcall, sel}, 3'b110);
        for (int i = 0; i < 4; i++) begin
            wr_byte(8'h5A, ak);
            check(ak, "R4", "general call data ack", ak, 1);
        end
        t_stop();
        check(we_cnt == 0 && !gcall, "R4", "no access after general call", we_cnt, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule